// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block arbitrates the interrupt sources of a small 8-bit microcontroller core. It has five sources. A non-maskable line, two external port lines, a timer underflow flag and an analog-converter end-of-conversion flag. It picks the most urgent pending request, holds it, and presents that source's 12-bit vector address to the core together with a request strobe. The core pulses an acknowledge input when it takes the vector. That pulse releases the controller so it can serve the next request, and it clears any edge that was latched for the source just served.

A single write-only option register on the 8-bit register bus sets three things. It enables all maskable sources together. It chooses falling edge or low level for the first port line. It chooses falling or rising edge for the second port line. A wake output tells the core's clock control that a source able to end a STOP or WAIT state is pending. The non-maskable source can still be served while the global enable is off, but in that state it does not raise the wake output.

Top module: `irqv_top`

## Requirements
- R1: The option register is written only by a bus write to address C8h. Bit 6 is the port A mode, bit 5 is the port B edge and bit 4 is the global enable. Bits 7 and 3:0 are ignored. The register resets to 00h and has no read path.
- R2: When several requests are eligible in the same cycle, the controller serves them in this order: NMI, port A, port B, timer, ADC. The vectors are FFCh, FF6h, FF4h, FF2h and FF0h respectively.
- R3: With nothing in service, `irqReq` is 0 and `irqVector` shows the reset vector FFEh.
- R4: While the global enable is 0, requests from port A, port B, the timer and the ADC are not served.
- R5: A falling edge on `nmiPin` is latched and served whatever the global enable is.
- R6: `wakeOut` is 1 exactly when the global enable is 1 and at least one NMI, port A, port B or timer request is pending. ADC requests never assert it.
- R7: With bit 6 at 0, a falling edge on `portAPin` is latched. With bit 6 at 1, port A requests service for as long as the pin is low.
- R8: With bit 5 at 0, a falling edge on `portBPin` is latched. With bit 5 at 1, a rising edge is latched and falling edges are ignored.
- R9: Once a vector is presented, `irqReq` and `irqVector` stay unchanged until `irqAck` arrives, even if a request of higher priority arrives in the meantime.
- R10: An `irqAck` while `irqReq` is 1 drops `irqReq` on the next cycle and clears the latched edge of the source that was served. The next eligible request is presented one cycle after that.
- R11: The timer and ADC inputs are level flags. They request service while high, so a flag that is still high after acknowledge is served again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| busWrEn | input | 1 | Register bus write strobe |
| busAddr | input | 8 | Register bus address |
| busWrData | input | 8 | Register bus write data |
| nmiPin | input | 1 | Non-maskable line, asynchronous, idle high |
| portAPin | input | 1 | Port A interrupt line, asynchronous, idle high |
| portBPin | input | 1 | Port B interrupt line, asynchronous, idle high |
| timerFlag | input | 1 | Timer underflow flag, synchronous level |
| adcFlag | input | 1 | End-of-conversion flag, synchronous level |
| irqAck | input | 1 | Core acknowledge of the presented vector |
| irqReq | output | 1 | Interrupt request to the core |
| irqVector | output | 12 | Vector address of the source in service |
| wakeOut | output | 1 | Pending source able to end STOP or WAIT |

## Verification
The main sweep raises every one of the 32 subsets of the five sources in the same cycle with the enable on. It then acknowledges them one by one, so the order in which vectors appear shows the full priority chain, and the wake value at each step separates the four wake-capable sources from the ADC. Separate patterns exercise the controller with the enable off and with non-maskable activity only. They also drive each port line with both edges under each mode setting, send writes to a wrong address and writes with reserved bits set, and raise a high-priority request while a low-priority one is being served. Together these tell apart masking from latching, level mode from edge mode, and holding from preemption.

// File: rtl/irqv_pkg.sv
package irqv_pkg;
  typedef enum logic [2:0] {
    SRC_NONE, SRC_NMI, SRC_PORTA, SRC_PORTB, SRC_TIMER, SRC_ADC
  } srcT;

  typedef struct packed {
    logic clrNmi;
    logic clrPortA;
    logic clrPortB;
  } clrStrobeT;

  typedef struct packed {
    logic nmi;
    logic portA;
    logic portB;
    logic timer;
    logic adc;
  } reqT;

  localparam int MODE_A_BIT = 6;
  localparam int EDGE_B_BIT = 5;
  localparam int GEN_BIT    = 4;

  // two-byte slot index below the top of the vector space
  function automatic logic [3:0] slotOf(srcT s);
    case (s)
      SRC_NMI:   return 4'd1;
      SRC_PORTA: return 4'd4;
      SRC_PORTB: return 4'd5;
      SRC_TIMER: return 4'd6;
      SRC_ADC:   return 4'd7;
      default:   return 4'd0;
    endcase
  endfunction
endpackage

// File: rtl/irqv_datapath.sv
module irqv_datapath
  import irqv_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter logic [ADDR_W-1:0] OPT_ADDR = 8'hC8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWrEn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWrData,
  input  logic              nmiPin,
  input  logic              portAPin,
  input  logic              portBPin,
  input  logic              timerFlag,
  input  logic              adcFlag,
  input  clrStrobeT         clr,
  output reqT               req,
  output logic              gen
);
  localparam int NPINS = 3;

  logic [NPINS-1:0] pinIn;
  logic [NPINS-1:0] synced;
  logic [NPINS-1:0] prevQ;
  logic [NPINS-1:0] fallE;
  logic [NPINS-1:0] riseE;
  logic modeAQ, edgeBQ, genQ;
  logic nmiPendQ, pendAQ, pendBQ;

  assign pinIn = {portBPin, portAPin, nmiPin};

  for (genvar g = 0; g < NPINS; g++) begin : gSync
    logic [SYNC_STAGES-1:0] chainQ;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) chainQ <= '1;
      else       chainQ <= {chainQ[SYNC_STAGES-2:0], pinIn[g]};
    end
    assign synced[g] = chainQ[SYNC_STAGES-1];
  end

  assign fallE = prevQ & ~synced;
  assign riseE = ~prevQ & synced;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevQ    <= '1;
      modeAQ   <= 1'b0;
      edgeBQ   <= 1'b0;
      genQ     <= 1'b0;
      nmiPendQ <= 1'b0;
      pendAQ   <= 1'b0;
      pendBQ   <= 1'b0;
    end else begin
      prevQ <= synced;
      if (busWrEn && busAddr == OPT_ADDR) begin
        modeAQ <= busWrData[MODE_A_BIT];
        edgeBQ <= busWrData[EDGE_B_BIT];
        genQ   <= busWrData[GEN_BIT];
      end
      // a new edge wins over a clear in the same cycle
      nmiPendQ <= (nmiPendQ & ~clr.clrNmi) | fallE[0];
      pendAQ   <= modeAQ ? 1'b0 : ((pendAQ & ~clr.clrPortA) | fallE[1]);
      pendBQ   <= (pendBQ & ~clr.clrPortB) | (edgeBQ ? riseE[2] : fallE[2]);
    end
  end

  assign req.nmi   = nmiPendQ;
  assign req.portA = modeAQ ? ~synced[1] : pendAQ;
  assign req.portB = pendBQ;
  assign req.timer = timerFlag;
  assign req.adc   = adcFlag;
  assign gen       = genQ;
endmodule

// File: rtl/irqv_control.sv
module irqv_control
  import irqv_pkg::*;
#(
  parameter int VEC_W = 12
) (
  input  logic             clk,
  input  logic             rstN,
  input  reqT              req,
  input  logic             gen,
  input  logic             irqAck,
  output clrStrobeT        clr,
  output logic             irqReq,
  output logic [VEC_W-1:0] irqVector,
  output logic             wakeOut
);
  localparam logic [VEC_W-1:0] TOP_VEC = {{(VEC_W-1){1'b1}}, 1'b0};

  srcT  pick, servQ;
  logic busyQ;
  logic takeAck;

  always_comb begin
    pick = SRC_NONE;
    if (req.nmi)              pick = SRC_NMI;
    else if (gen && req.portA) pick = SRC_PORTA;
    else if (gen && req.portB) pick = SRC_PORTB;
    else if (gen && req.timer) pick = SRC_TIMER;
    else if (gen && req.adc)   pick = SRC_ADC;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busyQ <= 1'b0;
      servQ <= SRC_NONE;
    end else if (!busyQ) begin
      if (pick != SRC_NONE) begin
        busyQ <= 1'b1;
        servQ <= pick;
      end
    end else if (irqAck) begin
      busyQ <= 1'b0;
      servQ <= SRC_NONE;
    end
  end

  assign takeAck      = busyQ && irqAck;
  assign clr.clrNmi   = takeAck && servQ == SRC_NMI;
  assign clr.clrPortA = takeAck && servQ == SRC_PORTA;
  assign clr.clrPortB = takeAck && servQ == SRC_PORTB;

  assign irqReq    = busyQ;
  assign irqVector = TOP_VEC - VEC_W'({slotOf(servQ), 1'b0});
  assign wakeOut   = gen && (req.nmi || req.portA || req.portB || req.timer);
endmodule

// File: rtl/irqv_top.sv
module irqv_top
  import irqv_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter logic [ADDR_W-1:0] OPT_ADDR = 8'hC8,
  parameter int SYNC_STAGES = 2,
  parameter int VEC_W = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWrEn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWrData,
  input  logic              nmiPin,
  input  logic              portAPin,
  input  logic              portBPin,
  input  logic              timerFlag,
  input  logic              adcFlag,
  input  logic              irqAck,
  output logic              irqReq,
  output logic [VEC_W-1:0]  irqVector,
  output logic              wakeOut
);
  reqT       req;
  clrStrobeT clr;
  logic      gen;

  irqv_datapath #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .OPT_ADDR(OPT_ADDR), .SYNC_STAGES(SYNC_STAGES)
  ) u_dp (
    .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busAddr(busAddr),
    .busWrData(busWrData), .nmiPin(nmiPin), .portAPin(portAPin),
    .portBPin(portBPin), .timerFlag(timerFlag), .adcFlag(adcFlag),
    .clr(clr), .req(req), .gen(gen)
  );

  irqv_control #(.VEC_W(VEC_W)) u_ctl (
    .clk(clk), .rstN(rstN), .req(req), .gen(gen), .irqAck(irqAck),
    .clr(clr), .irqReq(irqReq), .irqVector(irqVector), .wakeOut(wakeOut)
  );
endmodule

// File: rtl/irqv_checker.sv
module irqv_checker #(
  parameter int VEC_W = 12
) (
  input logic             clk,
  input logic             rstN,
  input logic             irqReq,
  input logic             irqAck,
  input logic [VEC_W-1:0] irqVector,
  input logic             wakeOut,
  input logic             gen
);
  localparam logic [VEC_W-1:0] RST_VEC = {{(VEC_W-1){1'b1}}, 1'b0};
  localparam logic [VEC_W-1:0] NMI_VEC = RST_VEC - VEC_W'(2);

  AST_IDLE_RESET_VEC: assert property (@(posedge clk) disable iff (!rstN)
    !irqReq |-> irqVector == RST_VEC); // R3

  AST_HOLD_UNTIL_ACK: assert property (@(posedge clk) disable iff (!rstN)
    (irqReq && !irqAck) |=> (irqReq && $stable(irqVector))); // R9

  AST_ACK_DROPS_REQ: assert property (@(posedge clk) disable iff (!rstN)
    (irqReq && irqAck) |=> !irqReq); // R10

  AST_MASKED_NO_WAKE: assert property (@(posedge clk) disable iff (!rstN)
    !gen |-> !wakeOut); // R6

  AST_MASKED_ONLY_NMI: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(irqReq) && !$past(gen)) |-> irqVector == NMI_VEC); // R4
endmodule

bind irqv_top irqv_checker #(.VEC_W(VEC_W)) chk_i (
  .clk(clk), .rstN(rstN), .irqReq(irqReq), .irqAck(irqAck),
  .irqVector(irqVector), .wakeOut(wakeOut), .gen(gen)
);

// File: tb/irqv_top_tb.sv
module irqv_top_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic busWrEn = 1'b0;
  logic [7:0] busAddr = '0;
  logic [7:0] busWrData = '0;
  logic nmiPin = 1'b1, portAPin = 1'b1, portBPin = 1'b1;
  logic timerFlag = 1'b0, adcFlag = 1'b0, irqAck = 1'b0;
  logic irqReq, wakeOut;
  logic [11:0] irqVector;
  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  irqv_top dut_i (
    .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busAddr(busAddr),
    .busWrData(busWrData), .nmiPin(nmiPin), .portAPin(portAPin),
    .portBPin(portBPin), .timerFlag(timerFlag), .adcFlag(adcFlag),
    .irqAck(irqAck), .irqReq(irqReq), .irqVector(irqVector), .wakeOut(wakeOut)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wrBus(logic [7:0] a, logic [7:0] d);
    busWrEn = 1'b1; busAddr = a; busWrData = d;
    tick(1);
    busWrEn = 1'b0;
  endtask

  task automatic ack(logic clrTimer, logic clrAdc);
    irqAck = 1'b1;
    if (clrTimer) timerFlag = 1'b0;
    if (clrAdc) adcFlag = 1'b0;
    tick(1);
    irqAck = 1'b0;
  endtask

  task automatic chkServe(string tag, logic [11:0] vec);
    chk({tag, " req"}, {31'b0, irqReq}, 32'd1);
    chk({tag, " vector"}, {20'b0, irqVector}, {20'b0, vec});
  endtask

  function automatic logic [11:0] expVec(int idx);
    case (idx)
      0: return 12'hFFC;
      1: return 12'hFF6;
      2: return 12'hFF4;
      3: return 12'hFF2;
      default: return 12'hFF0;
    endcase
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk);
    chk("R3 reset req", {31'b0, irqReq}, 32'd0);
    chk("R3 reset vector", {20'b0, irqVector}, 32'hFFE);
    tick(2);
    rstN = 1'b1;
    tick(2);
    // R1: reset value 00h -> enable off, timer blocked
    timerFlag = 1'b1;
    tick(4);
    chk("R1 R4 reset gen off", {31'b0, irqReq}, 32'd0);
    chk("R6 no wake when masked", {31'b0, wakeOut}, 32'd0);
    // R1: wrong address ignored
    wrBus(8'hC9, 8'h10);
    tick(4);
    chk("R1 wrong address", {31'b0, irqReq}, 32'd0);
    // R1: reserved bits ignored, enable takes effect
    wrBus(8'hC8, 8'h9F);
    tick(3);
    chkServe("R1 R11 timer served", 12'hFF2);
    // R11: flag still high -> served again
    ack(1'b0, 1'b0);
    tick(2);
    chkServe("R11 timer re-request", 12'hFF2);
    // R9: higher priority NMI arrives while timer is in service
    nmiPin = 1'b0;
    tick(6);
    chkServe("R9 hold timer", 12'hFF2);
    ack(1'b1, 1'b0);
    tick(2);
    chkServe("R10 R5 next NMI", 12'hFFC);
    ack(1'b0, 1'b0);
    tick(2);
    chk("R10 idle after acks", {31'b0, irqReq}, 32'd0);
    chk("R3 idle vector", {20'b0, irqVector}, 32'hFFE);
    nmiPin = 1'b1;

    // R4 R5 R6: enable off, NMI only
    wrBus(8'hC8, 8'h00);
    timerFlag = 1'b1;
    portAPin = 1'b0;
    tick(6);
    chk("R4 masked port A and timer", {31'b0, irqReq}, 32'd0);
    nmiPin = 1'b0;
    tick(6);
    chkServe("R5 NMI while masked", 12'hFFC);
    chk("R6 NMI no wake when masked", {31'b0, wakeOut}, 32'd0);
    ack(1'b0, 1'b0);
    tick(3);
    chk("R4 still masked after ack", {31'b0, irqReq}, 32'd0);
    wrBus(8'hC8, 8'h10);
    chk("R6 wake after enable", {31'b0, wakeOut}, 32'd1);
    tick(1);
    chkServe("R7 latched port A edge", 12'hFF6);
    ack(1'b0, 1'b0);
    tick(2);
    chkServe("R2 timer after port A", 12'hFF2);
    ack(1'b1, 1'b0);
    tick(2);
    chk("R10 port A latch cleared", {31'b0, irqReq}, 32'd0);
    nmiPin = 1'b1; portAPin = 1'b1;
    tick(6);

    // R7: level mode on port A
    wrBus(8'hC8, 8'h50);
    portAPin = 1'b0;
    tick(5);
    chkServe("R7 level port A", 12'hFF6);
    ack(1'b0, 1'b0);
    tick(2);
    chkServe("R7 level re-request", 12'hFF6);
    portAPin = 1'b1;
    tick(4);
    ack(1'b0, 1'b0);
    tick(3);
    chk("R7 level released", {31'b0, irqReq}, 32'd0);

    // R8: rising edge mode on port B
    wrBus(8'hC8, 8'h30);
    portBPin = 1'b0;
    tick(6);
    chk("R8 falling ignored", {31'b0, irqReq}, 32'd0);
    portBPin = 1'b1;
    tick(6);
    chkServe("R8 rising latched", 12'hFF4);
    ack(1'b0, 1'b0);
    tick(3);
    chk("R8 cleared by ack", {31'b0, irqReq}, 32'd0);

    // R2 R6 R10: all 32 subsets, falling edges, enable on
    wrBus(8'hC8, 8'h10);
    for (int m = 0; m < 32; m++) begin
      logic [4:0] pend;
      pend = m[4:0];
      nmiPin = ~pend[0]; portAPin = ~pend[1]; portBPin = ~pend[2];
      repeat (3) @(posedge clk);
      @(negedge clk);
      timerFlag = pend[3]; adcFlag = pend[4];
      tick(3);
      while (pend != 0) begin
        int idx;
        idx = 0;
        for (int k = 4; k >= 0; k--) if (pend[k]) idx = k;
        chkServe("R2 sweep", expVec(idx));
        chk("R6 sweep wake", {31'b0, wakeOut}, {31'b0, |pend[3:0]});
        ack(idx == 3, idx == 4);
        pend[idx] = 1'b0;
        tick(2);
      end
      chk("R10 sweep drained", {31'b0, irqReq}, 32'd0);
      chk("R6 sweep no wake", {31'b0, wakeOut}, 32'd0);
      nmiPin = 1'b1; portAPin = 1'b1; portBPin = 1'b1;
      tick(6);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule